// File: doc/BRIEF.md
# Translation Lookaside Cache with Single-Page Invalidate and Flush

This block holds a small, fully associative set of recent address translations at 4 KB page granularity. Each entry pairs a virtual page number with a physical page number, a readable flag and a writable flag. A requester presents a virtual address and, in the same cycle, sees whether the page is cached along with its physical page number and permissions.

A table walker installs translations through the fill port by handing over the virtual address and the leaf descriptor it fetched. Software-driven maintenance uses two other inputs. The first removes the single entry for one virtual page. The second empties the whole cache, for example when a page fault is retired, before the fault is acknowledged. When a new page arrives and the cache is full, an entry is chosen by round-robin. Free entries are always used first.

Top module: `xlate_cache`

## Requirements
- R1: After reset every entry is empty, so every lookup misses until a fill is accepted.
- R2: The page tag is virtual address bits 31:12, and bits 11:0 do not affect matching. A lookup whose page is cached raises the hit output combinationally in the same cycle. It returns the descriptor's bits 31:12 as the physical page number, descriptor bit 1 as the read permission and descriptor bit 2 as the write permission. A fill becomes visible to lookups from the cycle after its clock edge.
- R3: A fill whose descriptor bit 0 (valid) is clear is ignored and changes no entry.
- R4: A fill for a page that is already cached overwrites that entry in place and allocates no second entry.
- R5: A fill for a new page goes into the lowest-numbered empty entry when one exists.
- R6: When all entries are valid, a fill for a new page replaces the entry named by a round-robin pointer. The pointer is 0 after reset, advances by one (wrapping at the entry count) after each such replacement, and is not moved by fills into empty or matching entries.
- R7: An invalidate removes only the entry whose page equals the invalidate address's page. All other entries remain valid. The fill target for the same cycle is chosen from the state before the invalidate.
- R8: A flush request empties every entry at the clock edge.
- R9: When an invalidate and a fill name the same page in one cycle, the invalidate wins and that page is not cached afterwards.
- R10: A flush in the same cycle as a fill wins, and the cache is empty afterwards.
- R11: On a miss, the physical page number, read and write outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | VA_W (32) | Lookup virtual address |
| lk_hit | output | 1 | Lookup page is cached |
| lk_ppn | output | PA_W-PG_W (20) | Physical page number of the hit |
| lk_rd | output | 1 | Read permitted |
| lk_wr | output | 1 | Write permitted |
| fill_valid | input | 1 | Install a translation this cycle |
| fill_va | input | VA_W (32) | Virtual address being installed |
| fill_desc | input | PA_W (32) | Leaf descriptor: 31:12 page, 2 write, 1 read, 0 valid |
| inv_valid | input | 1 | Remove one page this cycle |
| inv_va | input | VA_W (32) | Virtual address of the page to remove |
| flush | input | 1 | Remove all entries this cycle |

## Verification
If a valid bit, tag or payload is stored wrongly, it shows up on the first lookup of the affected page in the cycle after the update: a missed hit, a phantom hit, or a wrong page number or permission. A wrong victim choice or round-robin pointer stays hidden until the cache is full and a replacement happens. It then shows as a surviving page that should have been evicted, or a missing page that should have survived. For this reason the bench probes every cached page after each eviction. The reference model runs alongside the design and compares the lookup outputs on every cycle, so any error is reported in the cycle it first becomes visible.

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [VA_W-1:0]      lk_va,
  output logic                 lk_hit,
  output logic [PA_W-PG_W-1:0] lk_ppn,
  output logic                 lk_rd,
  output logic                 lk_wr,
  input  logic                 fill_valid,
  input  logic [VA_W-1:0]      fill_va,
  input  logic [PA_W-1:0]      fill_desc,
  input  logic                 inv_valid,
  input  logic [VA_W-1:0]      inv_va,
  input  logic                 flush
);
  localparam int VPN_W = VA_W - PG_W;
  localparam int PPN_W = PA_W - PG_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [PPN_W-1:0]   ppn [ENTRIES];
  logic [ENTRIES-1:0] prd, pwr;
  logic [IDX_W-1:0]   rr;

  wire [VPN_W-1:0] lvpn = lk_va[VA_W-1:PG_W];
  wire [VPN_W-1:0] fvpn = fill_va[VA_W-1:PG_W];
  wire [VPN_W-1:0] ivpn = inv_va[VA_W-1:PG_W];
  wire fill_do = fill_valid && fill_desc[0] && !(inv_valid && ivpn == fvpn);

  logic unused_ok;
  assign unused_ok = ^{lk_va[PG_W-1:0], fill_va[PG_W-1:0], inv_va[PG_W-1:0], fill_desc[PG_W-1:3]};

  logic             has_match, has_free;
  logic [IDX_W-1:0] idx_match, idx_free, tgt;

  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    lk_rd  = 1'b0;
    lk_wr  = 1'b0;
    has_match = 1'b0;
    has_free  = 1'b0;
    idx_match = '0;
    idx_free  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld[i] && tag[i] == lvpn) begin
        lk_hit = 1'b1;
        lk_ppn = lk_ppn | ppn[i];
        lk_rd  = lk_rd | prd[i];
        lk_wr  = lk_wr | pwr[i];
      end
    end
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (vld[i] && tag[i] == fvpn) begin
        has_match = 1'b1;
        idx_match = IDX_W'(i);
      end
      if (!vld[i]) begin
        has_free = 1'b1;
        idx_free = IDX_W'(i);
      end
    end
    tgt = has_match ? idx_match : (has_free ? idx_free : rr);
  end

  wire evict = fill_do && !has_match && !has_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else if (flush) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (inv_valid && vld[i] && tag[i] == ivpn && !(fill_do && tgt == IDX_W'(i)))
          vld[i] <= 1'b0;
      if (fill_do) begin
        vld[tgt] <= 1'b1;
        tag[tgt] <= fvpn;
        ppn[tgt] <= fill_desc[PA_W-1:PG_W];
        prd[tgt] <= fill_desc[1];
        pwr[tgt] <= fill_desc[2];
      end
      if (evict)
        rr <= (rr == IDX_W'(ENTRIES-1)) ? '0 : rr + 1'b1;
    end
  end
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int PG_W = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [VA_W-1:0]      lk_va,
  input logic                 lk_hit,
  input logic [PA_W-PG_W-1:0] lk_ppn,
  input logic                 lk_rd,
  input logic                 lk_wr,
  input logic                 fill_valid,
  input logic [VA_W-1:0]      fill_va,
  input logic [PA_W-1:0]      fill_desc,
  input logic                 inv_valid,
  input logic [VA_W-1:0]      inv_va,
  input logic                 flush
);
  p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ppn == '0 && !lk_rd && !lk_wr));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  p_inv_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> (lk_va[VA_W-1:PG_W] != $past(inv_va[VA_W-1:PG_W]) || !lk_hit));

  p_fill_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_desc[0] && !inv_valid && !flush) |=>
      (lk_va[VA_W-1:PG_W] != $past(fill_va[VA_W-1:PG_W]) ||
       (lk_hit && lk_ppn == $past(fill_desc[PA_W-1:PG_W]) &&
        lk_rd == $past(fill_desc[1]) && lk_wr == $past(fill_desc[2]))));

  p_reset_empty_r1: assert property (@(posedge clk)
    !rst_n |=> !lk_hit);
endmodule

bind xlate_cache xlate_cache_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
  .lk_rd(lk_rd), .lk_wr(lk_wr), .fill_valid(fill_valid), .fill_va(fill_va),
  .fill_desc(fill_desc), .inv_valid(inv_valid), .inv_va(inv_va), .flush(flush));

// File: tb/test_xlate_cache.sv
`timescale 1ns/1ps
module test_xlate_cache;
  localparam int N = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_va = 0, fill_va = 0, fill_desc = 0, inv_va = 0;
  logic        fill_valid = 0, inv_valid = 0, flush = 0;
  logic        lk_hit, lk_rd, lk_wr;
  logic [19:0] lk_ppn;

  xlate_cache i_xlate_cache (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .lk_rd(lk_rd), .lk_wr(lk_wr), .fill_valid(fill_valid), .fill_va(fill_va),
    .fill_desc(fill_desc), .inv_valid(inv_valid), .inv_va(inv_va), .flush(flush));

  always #2 clk = ~clk;

  bit        m_v [N];
  int        m_tag [N];
  int        m_ppn [N];
  bit        m_rd [N], m_wr [N];
  int        m_rr = 0;
  int        vectors = 0, errors = 0;
  string     req = "R1";
  bit        done = 0;

  task automatic compare();
    bit eh = 0; int ep = 0; bit er = 0, ew = 0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_tag[i] == int'(lk_va[31:12])) begin
        eh = 1; ep = m_ppn[i]; er = m_rd[i]; ew = m_wr[i];
      end
    vectors++;
    if (lk_hit !== eh || int'(lk_ppn) != ep || lk_rd !== er || lk_wr !== ew) begin
      errors++;
      $display("FAIL %s va=%h actual hit=%0d ppn=%h r=%0d w=%0d expected hit=%0d ppn=%h r=%0d w=%0d",
               req, lk_va, lk_hit, lk_ppn, lk_rd, lk_wr, eh, ep[19:0], er, ew);
    end
  endtask

  task automatic model_step();
    int fv, iv, t; bit fdo, hm, hf; int im, ifr;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_rr = 0;
      return;
    end
    if (flush) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      return;
    end
    fv = int'(fill_va[31:12]);
    iv = int'(inv_va[31:12]);
    fdo = fill_valid && fill_desc[0] && !(inv_valid && iv == fv);
    hm = 0; hf = 0; im = 0; ifr = 0;
    for (int i = N-1; i >= 0; i--) begin
      if (m_v[i] && m_tag[i] == fv) begin hm = 1; im = i; end
      if (!m_v[i]) begin hf = 1; ifr = i; end
    end
    t = hm ? im : (hf ? ifr : m_rr);
    if (inv_valid)
      for (int i = 0; i < N; i++)
        if (m_tag[i] == iv) m_v[i] = 0;
    if (fdo) begin
      m_v[t] = 1; m_tag[t] = fv; m_ppn[t] = int'(fill_desc[31:12]);
      m_rd[t] = fill_desc[1]; m_wr[t] = fill_desc[2];
      if (!hm && !hf) m_rr = (m_rr + 1) % N;
    end
  endtask

  task automatic cyc(input logic [31:0] va, input bit fv_, input logic [31:0] fa,
                     input logic [31:0] fd, input bit iv_, input logic [31:0] ia, input bit fl);
    lk_va = va; fill_valid = fv_; fill_va = fa; fill_desc = fd;
    inv_valid = iv_; inv_va = ia; flush = fl;
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] va);
    cyc(va, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] fd, input logic [31:0] probe);
    cyc(probe, 1, va, fd, 0, 0, 0);
  endtask

  function automatic logic [31:0] pg(input int n);
    return {n[19:0], 12'h000};
  endfunction

  task automatic probe_all();
    for (int k = 0; k < 16; k++) look(pg(32'h100 + k) | 32'h7f3);
  endtask

  initial begin
    @(negedge clk);
    req = "R1";
    look(pg(1)); look(pg(32'h100));
    @(posedge clk); model_step(); @(negedge clk);
    rst_n = 1;
    look(pg(0)); look(pg(32'h100));

    req = "R5";
    fill(pg(32'h100), {20'hA0001, 12'h003}, pg(32'h100));
    req = "R2";
    look(pg(32'h100) | 32'hfff);
    look(pg(32'h100));
    fill(pg(32'h101), {20'hA0002, 12'h005}, pg(32'h101));
    fill(pg(32'h102), {20'hA0003, 12'h007}, pg(32'h101));
    look(pg(32'h102) | 32'h123);
    req = "R11";
    look(pg(32'h200)); look(32'h0010_1000);

    req = "R3";
    fill(pg(32'h103), {20'hBBBBB, 12'h006}, pg(32'h103));
    look(pg(32'h103));
    fill(pg(32'h100), {20'hCCCCC, 12'h006}, pg(32'h100));
    look(pg(32'h100));

    req = "R4";
    fill(pg(32'h101), {20'hD0D0D, 12'h003}, pg(32'h101));
    look(pg(32'h101));
    probe_all();

    req = "R6";
    for (int k = 3; k < 8; k++) fill(pg(32'h100 + k), {20'hE0000 + k[19:0], 12'h007}, pg(32'h100));
    probe_all();
    fill(pg(32'h108), {20'hF0008, 12'h003}, pg(32'h100));
    probe_all();
    fill(pg(32'h109), {20'hF0009, 12'h005}, pg(32'h101));
    fill(pg(32'h10a), {20'hF000A, 12'h001}, pg(32'h102));
    probe_all();
    fill(pg(32'h104), {20'h44444, 12'h003}, pg(32'h104));
    fill(pg(32'h10b), {20'hF000B, 12'h007}, pg(32'h103));
    probe_all();

    req = "R7";
    cyc(pg(32'h105), 0, 0, 0, 1, pg(32'h105) | 32'h0ab, 0);
    probe_all();
    cyc(pg(32'h106), 1, pg(32'h10c), {20'h0C0C0, 12'h003}, 1, pg(32'h106), 0);
    probe_all();
    fill(pg(32'h10d), {20'h0D0D0, 12'h005}, pg(32'h10d));
    probe_all();

    req = "R9";
    cyc(pg(32'h107), 1, pg(32'h107), {20'h77777, 12'h007}, 1, pg(32'h107), 0);
    look(pg(32'h107));
    cyc(pg(32'h120), 1, pg(32'h120), {20'h12012, 12'h007}, 1, pg(32'h120), 0);
    look(pg(32'h120));
    probe_all();

    req = "R10";
    cyc(pg(32'h104), 1, pg(32'h130), {20'h13013, 12'h007}, 0, 0, 1);
    look(pg(32'h130)); look(pg(32'h104));

    req = "R8";
    fill(pg(32'h140), {20'h14014, 12'h003}, pg(32'h140));
    fill(pg(32'h141), {20'h14114, 12'h005}, pg(32'h140));
    look(pg(32'h141));
    cyc(pg(32'h140), 0, 0, 0, 0, 0, 1);
    look(pg(32'h140)); look(pg(32'h141));
    req = "R5";
    fill(pg(32'h150), {20'h15015, 12'h007}, pg(32'h150));
    look(pg(32'h150));
    probe_all();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule